// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader with Address-Width Probe

This block fetches 16-bit words from a three-wire serial EEPROM. It drives chip select, a serial clock and a serial data line into the device, and it samples the device's serial data output. The EEPROM may take either 6-bit or 8-bit word addresses. The block does not need to be told which. On the first request after reset it runs a probe read, watches where the device answers with its dummy zero bit, and keeps that width until the next reset. Every later read uses the detected width.

A client asks for a single word by index and receives it with a one-cycle valid pulse. A second request input starts a fixed sequence. That sequence reads three consecutive words from a base index, assembles them into a 48-bit station address and checks the result for a blank or erased pattern. The serial clock divider is worked out from the system clock frequency and the minimum half-period, so each serial clock phase lasts at least that long.

Top module: `uwire_rom_reader`

## Requirements
- R1: While reset is asserted, and right after it is released, chip select, serial clock, busy, both valid outputs and width_known are all low.
- R2: The first request after reset is preceded by one probe access. The probe sends start bit 1, opcode 10 and address 0xFF as 8 bits. The data-out sample taken during the sixth address bit decides the width: 1 gives 8-bit addresses (wide8=1), 0 gives 6-bit. The result and width_known=1 are held until reset, and no further probe is made.
- R3: A word read sends start bit 1, then opcode bits 1 and 0, then the word address MSB first at the detected width. It then clocks in 16 data bits MSB first, each sampled while the serial clock is high. The word is presented on rd_data together with a one-cycle rd_valid.
- R4: Chip select rises before the first serial clock of an access and falls after the last data bit. The serial clock is high only while chip select is high. An access holds exactly 3+W+16 clock pulses for address width W.
- R5: Every serial clock half-period inside an access lasts at least DIV system clocks, where DIV = ceil(CLK_HZ*HALF_NS/1e9), with a floor of 3.
- R6: A station address request reads words MAC_BASE, MAC_BASE+1 and MAC_BASE+2. Each word is stored little-endian, so mac_addr[47:40] is the low byte of the first word and mac_addr[7:0] is the high byte of the third. The result comes with a one-cycle mac_valid.
- R7: If the 18-bit sum of the three words is 0 or 0x2FFFD, mac_addr is all zeros and mac_bad is 1. Otherwise mac_bad is 0.
- R8: busy is high from the cycle after a request is accepted until its result is presented. Requests that arrive while busy is high are ignored and produce no result.
- R9: If rd_req and mac_req are both high in the same idle cycle, only the word read is performed.
- R10: In 6-bit mode only the low six bits of rd_index are sent, so indices that differ only in bits 7:6 return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Start a single word read (taken when idle) |
| rd_index | input | 8 | Word index for rd_req |
| rd_data | output | 16 | Last word read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| busy | output | 1 | An access sequence is in progress |
| mac_req | input | 1 | Start the three-word station address fetch |
| mac_addr | output | 48 | Assembled station address, zero when invalid |
| mac_valid | output | 1 | One-cycle pulse when mac_addr is updated |
| mac_bad | output | 1 | Last fetched station address was blank or invalid |
| wide8 | output | 1 | Detected address width is 8 bits (meaningful when width_known) |
| width_known | output | 1 | Address width probe has completed |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data out of the EEPROM |

## Verification
The bench builds the block with CLK_HZ = 125000000, HALF_NS = 40 and MAC_BASE = 10, which gives DIV = 5. That short half-period keeps a full access near 300 cycles, so dozens of random reads fit in each address-width mode. The behavioural EEPROM model is switched between 6-bit and 8-bit addressing across a reset, which exercises both outcomes of the probe. The index aliasing of the narrow mode and the exact clock count per chip-select window can both be checked there. Station-address words are loaded into the model at indices 10 to 12, covering an ordinary value, the all-ones blank and the all-zero case.

// File: rtl/uwire_rom_reader.sv
module uwire_rom_reader #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int HALF_NS  = 10_000,
  parameter int MAC_BASE = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [7:0]  rd_index,
  output logic [15:0] rd_data,
  output logic        rd_valid,
  output logic        busy,
  input  logic        mac_req,
  output logic [47:0] mac_addr,
  output logic        mac_valid,
  output logic        mac_bad,
  output logic        wide8,
  output logic        width_known,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);

  localparam longint NS_PER_S = 1_000_000_000;
  localparam longint DIV_RAW  = (longint'(CLK_HZ) * longint'(HALF_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam int     DIV      = (DIV_RAW < 3) ? 3 : int'(DIV_RAW);
  localparam int     CW       = $clog2(DIV);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [2:0]  RD_OP     = 3'b110;
  localparam logic [17:0] BLANK_SUM = 18'h2FFFD;
  localparam logic [4:0]  PROBE_BIT = 5'd8;

  typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_TAIL, ST_GAP} state_t;

  state_t      st;
  logic [CW-1:0] cnt;
  logic        phase, cs_r, probe, probe_bit, known, wide, op_mac;
  logic [4:0]  bitn, nbits;
  logic [10:0] cmd;
  logic [15:0] rx, w0, w1;
  logic [7:0]  idx;
  logic [1:0]  mac_cnt;
  logic        do_m, do_s;

  wire         cnt_done   = (cnt == CNT_LAST);
  wire [4:0]   data_start = nbits - 5'd16;
  wire [17:0]  sum_w      = 18'(w0) + 18'(w1) + 18'(rx);
  wire         sum_bad    = (sum_w == 18'd0) || (sum_w == BLANK_SUM);

  assign busy        = (st != ST_IDLE);
  assign ee_cs       = cs_r;
  assign ee_sk       = (st == ST_RUN) && phase;
  assign ee_di       = (st == ST_RUN) && (bitn < data_start) && cmd[10];
  assign wide8       = wide;
  assign width_known = known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; phase <= 1'b0; cs_r <= 1'b0;
      probe <= 1'b0; probe_bit <= 1'b0; known <= 1'b0; wide <= 1'b0;
      op_mac <= 1'b0; bitn <= '0; nbits <= '0; cmd <= '0; rx <= '0;
      w0 <= '0; w1 <= '0; idx <= '0; mac_cnt <= '0;
      do_m <= 1'b1; do_s <= 1'b1;
      rd_data <= '0; rd_valid <= 1'b0;
      mac_addr <= '0; mac_valid <= 1'b0; mac_bad <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      mac_valid <= 1'b0;
      do_m      <= ee_do;
      do_s      <= do_m;
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (rd_req) begin
            op_mac <= 1'b0;
            idx    <= rd_index;
            st     <= ST_LOAD;
          end else if (mac_req) begin
            op_mac  <= 1'b1;
            idx     <= 8'(MAC_BASE);
            mac_cnt <= 2'd0;
            st      <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          probe <= !known;
          if (!known)     cmd <= {RD_OP, 8'hFF};
          else if (wide)  cmd <= {RD_OP, idx};
          else            cmd <= {RD_OP, idx[5:0], 2'b00};
          nbits <= (!known || wide) ? 5'd27 : 5'd25;
          cs_r  <= 1'b1;
          phase <= 1'b0;
          cnt   <= '0;
          bitn  <= '0;
          st    <= ST_RUN;
        end
        ST_RUN: begin
          if (!cnt_done) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!phase) begin
              phase <= 1'b1;
            end else begin
              phase <= 1'b0;
              cmd   <= {cmd[9:0], 1'b0};
              if (bitn >= data_start) rx <= {rx[14:0], do_s};
              if (probe && bitn == PROBE_BIT) probe_bit <= do_s;
              if (bitn == nbits - 5'd1) st <= ST_TAIL;
              else bitn <= bitn + 5'd1;
            end
          end
        end
        ST_TAIL: begin
          if (!cnt_done) cnt <= cnt + 1'b1;
          else begin
            cnt  <= '0;
            cs_r <= 1'b0;
            st   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (!cnt_done) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (probe) begin
              known <= 1'b1;
              wide  <= probe_bit;
              st    <= ST_LOAD;
            end else if (!op_mac) begin
              rd_data  <= rx;
              rd_valid <= 1'b1;
              st       <= ST_IDLE;
            end else if (mac_cnt == 2'd2) begin
              mac_bad   <= sum_bad;
              mac_addr  <= sum_bad ? 48'd0 :
                           {w0[7:0], w0[15:8], w1[7:0], w1[15:8], rx[7:0], rx[15:8]};
              mac_valid <= 1'b1;
              st        <= ST_IDLE;
            end else begin
              if (mac_cnt == 2'd0) w0 <= rx;
              else                 w1 <= rx;
              mac_cnt <= mac_cnt + 2'd1;
              idx     <= idx + 8'd1;
              st      <= ST_LOAD;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs); // R4
  AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) ee_cs |-> busy); // R8
  AST_SK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_sk) |=> ee_sk); // R5
  AST_SK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ee_sk) && ee_cs) |=> !ee_sk); // R5
  AST_WIDTH_STICKY: assert property (@(posedge clk) disable iff (!rst_n) width_known |=> width_known && $stable(wide8)); // R2
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R3
  AST_BAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (mac_valid && mac_bad) |-> mac_addr == 48'd0); // R7
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !(rd_valid && mac_valid)); // R9

endmodule

// File: tb/uwire_rom_reader_bench.sv
`timescale 1ns/1ps
module uwire_rom_reader_bench;
  localparam int CLK_HZ = 125_000_000, HALF_NS = 40, MAC_BASE = 10, DIV = 5;

  logic clk = 1'b0, rst_n = 1'b0, rd_req = 1'b0, mac_req = 1'b0;
  logic [7:0] rd_index = '0;
  logic [15:0] rd_data;
  logic rd_valid, busy, mac_valid, mac_bad, wide8, width_known, ee_cs, ee_sk, ee_di;
  logic [47:0] mac_addr;
  logic m_do = 1'b1;

  always #4 clk = ~clk;

  uwire_rom_reader #(.CLK_HZ(CLK_HZ), .HALF_NS(HALF_NS), .MAC_BASE(MAC_BASE)) u_uwire_rom_reader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_index(rd_index), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .mac_req(mac_req), .mac_addr(mac_addr),
    .mac_valid(mac_valid), .mac_bad(mac_bad), .wide8(wide8), .width_known(width_known),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(m_do));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // EEPROM model
  int aw = 6;
  logic [15:0] mem [256];
  bit m_on = 1'b0;
  int m_cnt = 0;
  logic [1:0] m_op, last_op;
  logic [7:0] m_addr, last_addr;
  logic [15:0] m_out;

  always @(negedge ee_cs) begin m_on = 1'b0; m_cnt = 0; m_do = 1'b1; end
  always @(posedge ee_sk) if (ee_cs) begin
    if (!m_on) begin
      if (ee_di) begin m_on = 1'b1; m_cnt = 0; m_op = '0; m_addr = '0; end
    end else begin
      m_cnt++;
      if (m_cnt <= 2) m_op = {m_op[0], ee_di};
      else if (m_cnt <= 2 + aw) begin
        m_addr = {m_addr[6:0], ee_di};
        if (m_cnt == 2 + aw) begin
          last_addr = m_addr; last_op = m_op;
          if (m_op == 2'b10) begin m_do = 1'b0; m_out = mem[m_addr]; end
        end
      end else begin
        m_do = m_out[15]; m_out = {m_out[14:0], 1'b0};
      end
    end
  end

  // monitors
  int cs_wins = 0, win_clk = 0, last_clk = 0, rdv_n = 0, macv_n = 0, hcnt = 0, hmin = 1000;
  logic sk_q = 1'b0, cs_q = 1'b0;
  always @(posedge ee_cs) begin cs_wins++; win_clk = 0; end
  always @(posedge ee_sk) win_clk++;
  always @(negedge ee_cs) last_clk = win_clk;
  always @(posedge clk) begin
    if (rd_valid) rdv_n++;
    if (mac_valid) macv_n++;
    if (ee_sk != sk_q || (ee_cs && !cs_q)) begin
      if (ee_cs && cs_q && ee_sk != sk_q && hcnt < hmin) hmin = hcnt;
      hcnt = 1;
    end else hcnt++;
    sk_q = ee_sk; cs_q = ee_cs;
  end

  function automatic logic [15:0] exp_rd(input logic [7:0] i);
    return (aw == 6) ? mem[i & 8'h3F] : mem[i];
  endfunction
  function automatic logic [48:0] exp_mac(input logic [15:0] a, b, c);
    logic [17:0] s = 18'(a) + 18'(b) + 18'(c);
    logic bad = (s == 18'd0) || (s == 18'h2FFFD);
    return {bad, bad ? 48'd0 : {a[7:0], a[15:8], b[7:0], b[15:8], c[7:0], c[15:8]}};
  endfunction

  task automatic issue_rd(input logic [7:0] i);
    @(negedge clk);
    while (busy) @(negedge clk);
    rd_index = i; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask
  task automatic wait_rd(output logic [15:0] d);
    int t = 0;
    while (!rd_valid && t < 4000) begin @(negedge clk); t++; end
    if (!rd_valid) chk(1'b0, "R3 read timeout", 0, 1);
    d = rd_data;
    @(negedge clk);
  endtask
  task automatic do_read(input logic [7:0] i, input string req);
    logic [15:0] d;
    issue_rd(i);
    wait_rd(d);
    chk(d == exp_rd(i), req, d, exp_rd(i));
  endtask
  task automatic do_mac(input string req);
    int t = 0;
    logic [48:0] e = exp_mac(mem[MAC_BASE], mem[MAC_BASE+1], mem[MAC_BASE+2]);
    @(negedge clk);
    while (busy) @(negedge clk);
    mac_req = 1'b1;
    @(negedge clk);
    mac_req = 1'b0;
    while (!mac_valid && t < 8000) begin @(negedge clk); t++; end
    chk(mac_valid && {mac_bad, mac_addr} == e, req, {mac_bad, mac_addr}, e);
    @(negedge clk);
  endtask
  task automatic do_reset(input int width);
    @(negedge clk);
    rst_n = 1'b0; aw = width;
    repeat (4) @(negedge clk);
    chk({ee_cs, ee_sk, busy, rd_valid, mac_valid, width_known} == 6'd0, "R1 in reset",
        {ee_cs, ee_sk, busy, rd_valid, mac_valid, width_known}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ee_cs, ee_sk, busy, rd_valid, mac_valid, width_known} == 6'd0, "R1 after reset",
        {ee_cs, ee_sk, busy, rd_valid, mac_valid, width_known}, 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w0c, n0;
    logic [15:0] d;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 40503) ^ 16'h3C5A);
    mem[10] = 16'h2301; mem[11] = 16'h6745; mem[12] = 16'hAB89;

    // 6-bit device
    do_reset(6);
    w0c = cs_wins;
    issue_rd(8'h03);
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    wait_rd(d);
    chk(d == exp_rd(8'h03), "R3 first read 6-bit", d, exp_rd(8'h03));
    chk(width_known && !wide8, "R2 detect 6-bit", {width_known, wide8}, 2'b10);
    chk(cs_wins - w0c == 2, "R2 probe then read", cs_wins - w0c, 2);
    chk(last_clk == 25, "R4 clocks 6-bit", last_clk, 25);
    chk(last_op == 2'b10 && last_addr == 8'h03, "R3 opcode and address", {last_op, last_addr}, {2'b10, 8'h03});
    w0c = cs_wins;
    do_read(8'hC5, "R10 index aliasing");
    chk(last_addr == 8'h05, "R10 low six bits sent", last_addr, 8'h05);
    chk(cs_wins - w0c == 1, "R2 no second probe", cs_wins - w0c, 1);

    // R8: request while busy ignored
    n0 = rdv_n;
    issue_rd(8'h07);
    repeat (3) @(negedge clk);
    rd_index = 8'h09; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wait_rd(d);
    chk(d == exp_rd(8'h07), "R8 first request served", d, exp_rd(8'h07));
    repeat (800) @(negedge clk);
    chk(rdv_n - n0 == 1, "R8 busy request ignored", rdv_n - n0, 1);

    // R9: simultaneous requests
    n0 = macv_n;
    @(negedge clk);
    rd_index = 8'h21; rd_req = 1'b1; mac_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; mac_req = 1'b0;
    wait_rd(d);
    chk(d == exp_rd(8'h21), "R9 read wins", d, exp_rd(8'h21));
    repeat (1500) @(negedge clk);
    chk(macv_n == n0, "R9 no station fetch", macv_n - n0, 0);

    do_mac("R6 station address 6-bit");
    for (int k = 0; k < 30; k++) do_read(8'($urandom), "R3 random read 6-bit");

    // 8-bit device
    do_reset(8);
    w0c = cs_wins;
    do_read(8'hC5, "R3 first read 8-bit");
    chk(width_known && wide8, "R2 detect 8-bit", {width_known, wide8}, 2'b11);
    chk(cs_wins - w0c == 2, "R2 probe then read 8-bit", cs_wins - w0c, 2);
    chk(last_clk == 27, "R4 clocks 8-bit", last_clk, 27);
    chk(last_addr == 8'hC5, "R3 full address sent", last_addr, 8'hC5);
    do_mac("R6 station address 8-bit");
    mem[10] = 16'hFFFF; mem[11] = 16'hFFFF; mem[12] = 16'hFFFF;
    do_mac("R7 blank station address");
    chk(mac_bad == 1'b1, "R7 blank flagged", mac_bad, 1);
    mem[10] = 16'h0000; mem[11] = 16'h0000; mem[12] = 16'h0000;
    do_mac("R7 zero station address");
    for (int k = 0; k < 4; k++) begin
      mem[10] = 16'($urandom); mem[11] = 16'($urandom); mem[12] = 16'($urandom);
      do_mac("R6 random station address");
    end
    for (int k = 0; k < 30; k++) do_read(8'($urandom), "R3 random read 8-bit");

    chk(hmin >= DIV, "R5 minimum half period", hmin, DIV);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule